// File: doc/BRIEF.md
# Remote DMA Data Port

This block lets a host processor reach a network controller's local byte memory through one data port. The host first sets a remote pointer and a remaining byte count, each written as two single-byte halves. Every access to the data port then reads or writes 1, 2 or 4 bytes at the pointer. After the access the pointer moves on, the count goes down, and a sticky completion flag rises when the count runs out.

The memory has two parts: a small address PROM at the bottom of the address space and a packet-memory window higher up. An access that falls outside both parts reads as all ones and its write data is dropped. The pointer wraps from the ring's stop page back to its start page, so a host can walk through a circular receive ring without reprogramming the pointer.

A command write that starts a remote transfer while the count is already zero raises the completion flag at once. This lets drivers that issue zero-length transfers see them finish.

Top module: `rdma_port`

## Requirements
- R1: A register write with `reg_sel` 0, 1, 2 or 3 replaces only the low byte of the pointer, the high byte of the pointer, the low byte of the count or the high byte of the count. `addr_q` and `cnt_q` show the current values at all times. Reset clears both to zero.
- R2: A data-port access moves 4 bytes when `dp_long` is 1. Otherwise it moves 2 bytes when `wide_mode` is 1 and 1 byte when `wide_mode` is 0.
- R3: After an access the pointer grows by the access width. If the result equals the stop address (`ring_stop_pg` × 256), the pointer is loaded with the start address (`ring_start_pg` × 256) instead.
- R4: When the count before an access is less than or equal to the access width, the count becomes zero and `done_q` is set. Otherwise the count drops by the width. The count never goes below zero.
- R5: A data-port write while the count is zero has no effect on the pointer, the count, the flag or the memory. A read while the count is zero still returns data, still moves the pointer and sets `done_q`.
- R6: A command write whose bit 0 (stop) is 0, with bit 3 (remote read) or bit 4 (remote write) set, while the count is zero, sets `done_q` on that edge. Any other command write leaves the flag alone.
- R7: A byte is reachable when its address is below `PROM_BYTES` or inside [`PM_START`, `PM_START`+`PM_BYTES`). An access whose bytes are not all reachable reads as all ones over its width and writes nothing.
- R8: 2-byte and 4-byte accesses use the pointer with bit 0 cleared. Byte k of `dp_wdata`/`dp_rdata` maps to that address + k (little-endian). The pointer itself still advances from its unaligned value.
- R9: `done_q` stays set until `done_ack` is pulsed. A set event in the same cycle as `done_ack` wins.
- R10: Read data appears on `dp_rdata` at the clock edge that performs the read, zero-extended above the access width. `dp_rdata` holds its value until the next read. Reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for pointer/count halves; takes priority over a data-port access in the same cycle |
| reg_sel | input | 2 | 0 pointer low, 1 pointer high, 2 count low, 3 count high |
| reg_wdata | input | 8 | Byte written to the selected half |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte: bit 0 stop, bit 3 remote read, bit 4 remote write |
| wide_mode | input | 1 | Data-configuration width bit: 1 selects 2-byte port accesses |
| ring_start_pg | input | AW-8 | Ring start page |
| ring_stop_pg | input | AW-8 | Ring stop page (end page plus one) |
| dp_req | input | 1 | Data-port access strobe, one cycle per access |
| dp_write | input | 1 | 1 for a write access, 0 for a read |
| dp_long | input | 1 | 1 for a 4-byte access |
| dp_wdata | input | 32 | Write data, little-endian lanes |
| dp_rdata | output | 32 | Registered read data |
| done_ack | input | 1 | Clears the completion flag |
| addr_q | output | AW | Current remote pointer |
| cnt_q | output | 16 | Remaining byte count |
| done_q | output | 1 | Sticky remote-DMA-complete flag |

## Verification
The pointer, the count, the completion flag and the read data are all updated on the same rising edge that samples the stimulus. None of them has a pipeline stage beyond that edge. The bench drives every strobe for exactly one cycle, starting on a falling edge, and drops it on the next falling edge. It compares the outputs at that falling edge, half a cycle after the update. So each check covers exactly one stimulus, and the expected value comes from the width, the stop and start pages and the byte pattern written earlier.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   localparam int CNT_W = 16;

   typedef enum logic [1:0] {
      SEL_PTR_LO = 2'd0,
      SEL_PTR_HI = 2'd1,
      SEL_CNT_LO = 2'd2,
      SEL_CNT_HI = 2'd3
   } rdma_sel_e;

   localparam int CMD_HALT_BIT  = 0;
   localparam int CMD_RD_BIT    = 3;
   localparam int CMD_WR_BIT    = 4;

   // bytes moved by one data-port access
   function automatic logic [2:0] acc_width(input logic is_long, input logic is_wide);
      return is_long ? 3'd4 : (is_wide ? 3'd2 : 3'd1);
   endfunction

endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr
   import rdma_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              cmd_we,
   input  logic [7:0]        cmd_wdata,
   input  logic              step,
   input  logic [2:0]        width,
   input  logic [AW-1:0]     start_addr,
   input  logic [AW-1:0]     stop_addr,
   input  logic              done_ack,
   output logic [AW-1:0]     addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              done_q
);

   localparam int HW = AW - 8;

   logic [AW-1:0]    w_a;
   logic [CNT_W-1:0] w_c;
   logic [AW-1:0]    adv;
   logic             last_hit;
   logic             zero_go;

   assign w_a      = AW'(width);
   assign w_c      = CNT_W'(width);
   assign adv      = addr_q + w_a;
   assign last_hit = step && (cnt_q <= w_c);
   assign zero_go  = cmd_we && !cmd_wdata[CMD_HALT_BIT]
                     && (cmd_wdata[CMD_RD_BIT] || cmd_wdata[CMD_WR_BIT])
                     && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (reg_we) begin
         case (rdma_sel_e'(reg_sel))
            SEL_PTR_LO: addr_q[7:0]    <= reg_wdata;
            SEL_PTR_HI: addr_q[AW-1:8] <= reg_wdata[HW-1:0];
            SEL_CNT_LO: cnt_q[7:0]     <= reg_wdata;
            SEL_CNT_HI: cnt_q[15:8]    <= reg_wdata;
            default: ;
         endcase
      end else if (step) begin
         addr_q <= (adv == stop_addr) ? start_addr : adv;
         cnt_q  <= last_hit ? '0 : cnt_q - w_c;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   done_q <= 1'b0;
      else if (last_hit || zero_go) done_q <= 1'b1;
      else if (done_ack)            done_q <= 1'b0;
   end

endmodule

// File: rtl/rdma_store.sv
module rdma_store #(
   parameter int AW         = 16,
   parameter int PROM_BYTES = 32,
   parameter int PM_START   = 16'h4000,
   parameter int PM_BYTES   = 1024
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] base,
   input  logic [2:0]    nbytes,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);

   localparam int LANES = 4;
   localparam int PR_AW = $clog2(PROM_BYTES);
   localparam int PM_AW = $clog2(PM_BYTES);
   localparam logic [AW:0] PR_END = (AW+1)'(PROM_BYTES);
   localparam logic [AW:0] PM_LO  = (AW+1)'(PM_START);
   localparam logic [AW:0] PM_HI  = (AW+1)'(PM_START + PM_BYTES);

   logic [7:0] prom [PROM_BYTES];
   logic [7:0] pm   [PM_BYTES];

   logic [LANES-1:0] used, in_prom, in_pm;
   logic [PR_AW-1:0] pr_idx [LANES];
   logic [PM_AW-1:0] pm_idx [LANES];
   logic [7:0]       lane_rd [LANES];
   logic             hit;

   assign hit = (((in_prom | in_pm) & used) == used);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [AW:0] la;
      assign la         = {1'b0, base} + (AW+1)'(i);
      assign used[i]    = (3'(i) < nbytes);
      assign in_prom[i] = (la < PR_END);
      assign in_pm[i]   = (la >= PM_LO) && (la < PM_HI);
      assign pr_idx[i]  = PR_AW'(la);
      assign pm_idx[i]  = PM_AW'(la - PM_LO);
      assign lane_rd[i] = in_prom[i] ? prom[pr_idx[i]] : pm[pm_idx[i]];
      assign rdata[8*i +: 8] = !used[i] ? 8'h00 : (hit ? lane_rd[i] : 8'hFF);
   end

   always_ff @(posedge clk) begin
      if (we && hit) begin
         for (int i = 0; i < LANES; i++) begin
            if (used[i]) begin
               if (in_prom[i]) prom[pr_idx[i]] <= wdata[8*i +: 8];
               else            pm[pm_idx[i]]   <= wdata[8*i +: 8];
            end
         end
      end
   end

endmodule

// File: rtl/rdma_port.sv
module rdma_port
   import rdma_pkg::*;
#(
   parameter int AW         = 16,
   parameter int PROM_BYTES = 32,
   parameter int PM_START   = 16'h4000,
   parameter int PM_BYTES   = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              cmd_we,
   input  logic [7:0]        cmd_wdata,
   input  logic              wide_mode,
   input  logic [AW-9:0]     ring_start_pg,
   input  logic [AW-9:0]     ring_stop_pg,
   input  logic              dp_req,
   input  logic              dp_write,
   input  logic              dp_long,
   input  logic [31:0]       dp_wdata,
   output logic [31:0]       dp_rdata,
   input  logic              done_ack,
   output logic [AW-1:0]     addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              done_q
);

   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("rdma_port: AW must lie in 9..16");
   end
   if ((PROM_BYTES & (PROM_BYTES - 1)) != 0 || (PM_BYTES & (PM_BYTES - 1)) != 0) begin : g_bad_pow2
      $error("rdma_port: PROM_BYTES and PM_BYTES must be powers of two");
   end
   if (PM_START < PROM_BYTES || (PM_START % 256) != 0 || PM_START + PM_BYTES > (1 << AW)) begin : g_bad_win
      $error("rdma_port: packet window misplaced");
   end

   logic [2:0]    width;
   logic          step;
   logic [AW-1:0] base;
   logic [31:0]   st_rdata;

   assign width = acc_width(dp_long, wide_mode);
   assign step  = dp_req && !reg_we && (!dp_write || cnt_q != '0);
   assign base  = (width == 3'd1) ? addr_q : {addr_q[AW-1:1], 1'b0};

   rdma_ptr #(.AW(AW)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .cmd_we     (cmd_we),
      .cmd_wdata  (cmd_wdata),
      .step       (step),
      .width      (width),
      .start_addr ({ring_start_pg, 8'h00}),
      .stop_addr  ({ring_stop_pg, 8'h00}),
      .done_ack   (done_ack),
      .addr_q     (addr_q),
      .cnt_q      (cnt_q),
      .done_q     (done_q)
   );

   rdma_store #(
      .AW         (AW),
      .PROM_BYTES (PROM_BYTES),
      .PM_START   (PM_START),
      .PM_BYTES   (PM_BYTES)
   ) u_store (
      .clk    (clk),
      .we     (step && dp_write),
      .base   (base),
      .nbytes (width),
      .wdata  (dp_wdata),
      .rdata  (st_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 dp_rdata <= '0;
      else if (step && !dp_write) dp_rdata <= st_rdata;
   end

endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic          cmd_we,
   input logic [7:0]    cmd_wdata,
   input logic          wide_mode,
   input logic [AW-9:0] ring_start_pg,
   input logic [AW-9:0] ring_stop_pg,
   input logic          dp_req,
   input logic          dp_write,
   input logic          dp_long,
   input logic [31:0]   dp_rdata,
   input logic          done_ack,
   input logic [AW-1:0] addr_q,
   input logic [15:0]   cnt_q,
   input logic          done_q
);

   logic [2:0]    w;
   logic          acc;
   logic [AW-1:0] nxt;
   logic [AW-1:0] stop_a, start_a;

   assign w       = dp_long ? 3'd4 : (wide_mode ? 3'd2 : 3'd1);
   assign acc     = dp_req && !reg_we && (!dp_write || cnt_q != 16'd0);
   assign nxt     = addr_q + AW'(w);
   assign stop_a  = {ring_stop_pg, 8'h00};
   assign start_a = {ring_start_pg, 8'h00};

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cnt_q > 16'(w)) |=> (cnt_q == $past(cnt_q) - 16'($past(w))));

   assert_last_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cnt_q <= 16'(w)) |=> (cnt_q == 16'd0 && done_q));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && nxt == stop_a) |=> (addr_q == $past(start_a)));

   assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && nxt != stop_a) |=> (addr_q == $past(nxt)));

   assert_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && dp_write && !reg_we && cnt_q == 16'd0) |=> ($stable(addr_q) && cnt_q == 16'd0));

   assert_zero_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_wdata[0] && (cmd_wdata[3] || cmd_wdata[4]) && cnt_q == 16'd0) |=> done_q);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !done_ack) |=> done_q);

   assert_hold_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && !dp_write) |=> $stable(dp_rdata));

endmodule

bind rdma_port rdma_port_chk #(.AW(AW)) u_chk (.*);

// File: tb/rdma_port_test.sv
`timescale 1ns/1ps
module rdma_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_wdata = 8'd0;
   logic        wide_mode = 1'b0;
   logic [7:0]  ring_start_pg = 8'h40;
   logic [7:0]  ring_stop_pg = 8'h42;
   logic        dp_req = 1'b0;
   logic        dp_write = 1'b0;
   logic        dp_long = 1'b0;
   logic [31:0] dp_wdata = 32'd0;
   logic [31:0] dp_rdata;
   logic        done_ack = 1'b0;
   logic [15:0] addr_q;
   logic [15:0] cnt_q;
   logic        done_q;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   rdma_port uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [15:0] a);
      return (a[7:0] * 8'd29 + 8'd7) ^ a[15:8];
   endfunction

   task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
      @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = v;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic load(input logic [15:0] a, input logic [15:0] c);
      wr_reg(2'd0, a[7:0]); wr_reg(2'd1, a[15:8]);
      wr_reg(2'd2, c[7:0]); wr_reg(2'd3, c[15:8]);
   endtask

   task automatic cmd(input logic [7:0] v);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); done_ack = 1'b1;
      @(negedge clk); done_ack = 1'b0;
   endtask

   task automatic access(input logic wr, input logic lng, input logic [31:0] d);
      @(negedge clk); dp_req = 1'b1; dp_write = wr; dp_long = lng; dp_wdata = d;
      @(negedge clk); dp_req = 1'b0; dp_write = 1'b0; dp_long = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset pointer", 32'(addr_q), 32'h0);
      chk("R1 reset count", 32'(cnt_q), 32'h0);
      chk("R9 reset flag", 32'(done_q), 32'h0);
      chk("R10 reset rdata", dp_rdata, 32'h0);

      // R1 half writes
      wr_reg(2'd0, 8'h34); wr_reg(2'd1, 8'h12);
      chk("R1 pointer halves", 32'(addr_q), 32'h1234);
      wr_reg(2'd0, 8'hAB);
      chk("R1 pointer low only", 32'(addr_q), 32'h12AB);
      wr_reg(2'd3, 8'h07);
      chk("R1 count high only", 32'(cnt_q), 32'h0700);
      wr_reg(2'd2, 8'h09);
      chk("R1 count low only", 32'(cnt_q), 32'h0709);

      // R2 R3 R4 sweep, byte and word widths
      for (int m = 0; m < 2; m++) begin
         logic [15:0] b;
         int w;
         b = (m == 1) ? 16'h4080 : 16'h4000;
         w = (m == 1) ? 2 : 1;
         wide_mode = (m == 1);
         ack();
         load(b, 16'd12);
         for (int k = 0; k < 12 / w; k++) begin
            logic [15:0] a;
            a = b + 16'(k * w);
            access(1'b1, 1'b0, (w == 1) ? {24'h0, pat(a)} : {16'h0, pat(a + 16'd1), pat(a)});
            chk("R3 pointer step", 32'(addr_q), 32'(b) + 32'((k + 1) * w));
            chk("R4 count step", 32'(cnt_q), 32'(12 - (k + 1) * w));
            chk("R4 flag at end", 32'(done_q), 32'((k + 1) * w == 12));
         end
         wide_mode = 1'b0;
         load(b, 16'd12);
         for (int j = 0; j < 12; j++) begin
            access(1'b0, 1'b0, 32'h0);
            chk("R2 R8 byte readback", dp_rdata, {24'h0, pat(b + 16'(j))});
         end
         wide_mode = 1'b1;
         load(b, 16'd4);
         access(1'b0, 1'b0, 32'h0);
         chk("R10 word read zero-extended", dp_rdata, {16'h0, pat(b + 16'd1), pat(b)});
      end

      // R3 wrap with 4-byte accesses
      wide_mode = 1'b0;
      ack();
      load(16'h41F8, 16'd8);
      access(1'b1, 1'b1, {pat(16'h41FB), pat(16'h41FA), pat(16'h41F9), pat(16'h41F8)});
      chk("R2 long pointer", 32'(addr_q), 32'h41FC);
      chk("R4 long count", 32'(cnt_q), 32'd4);
      access(1'b1, 1'b1, {pat(16'h41FF), pat(16'h41FE), pat(16'h41FD), pat(16'h41FC)});
      chk("R3 wrap at stop", 32'(addr_q), 32'h4000);
      chk("R4 long done", 32'(done_q), 32'd1);
      load(16'h41FC, 16'd4);
      access(1'b0, 1'b1, 32'h0);
      chk("R8 long readback", dp_rdata, {pat(16'h41FF), pat(16'h41FE), pat(16'h41FD), pat(16'h41FC)});
      load(16'h41FF, 16'd2);
      access(1'b0, 1'b0, 32'h0);
      chk("R3 byte wrap data", dp_rdata, {24'h0, pat(16'h41FF)});
      chk("R3 byte wrap pointer", 32'(addr_q), 32'h4000);

      // R8 odd pointer, 2-byte write
      wide_mode = 1'b1;
      load(16'h4021, 16'd2);
      access(1'b1, 1'b0, 32'h0000BEEF);
      chk("R8 unaligned pointer advance", 32'(addr_q), 32'h4023);
      wide_mode = 1'b0;
      load(16'h4020, 16'd2);
      access(1'b0, 1'b0, 32'h0);
      chk("R8 low byte at even", dp_rdata, 32'h000000EF);
      access(1'b0, 1'b0, 32'h0);
      chk("R8 high byte at odd", dp_rdata, 32'h000000BE);

      // R4 saturation
      wide_mode = 1'b1;
      ack();
      load(16'h4040, 16'd3);
      access(1'b0, 1'b0, 32'h0);
      chk("R4 partial count", 32'(cnt_q), 32'd1);
      chk("R4 no early flag", 32'(done_q), 32'd0);
      access(1'b0, 1'b0, 32'h0);
      chk("R4 saturate", 32'(cnt_q), 32'd0);
      chk("R4 flag on last", 32'(done_q), 32'd1);
      chk("R3 pointer after sat", 32'(addr_q), 32'h4044);

      // R5 zero count
      wide_mode = 1'b0;
      ack();
      load(16'h4020, 16'd0);
      access(1'b1, 1'b0, 32'h55);
      chk("R5 write ignored pointer", 32'(addr_q), 32'h4020);
      chk("R5 write ignored count", 32'(cnt_q), 32'd0);
      chk("R5 write ignored flag", 32'(done_q), 32'd0);
      access(1'b0, 1'b0, 32'h0);
      chk("R5 read at zero data", dp_rdata, 32'h000000EF);
      chk("R5 read at zero pointer", 32'(addr_q), 32'h4021);
      chk("R5 read at zero flag", 32'(done_q), 32'd1);

      // R6 R9 command rule
      ack();
      chk("R9 ack clears", 32'(done_q), 32'd0);
      load(16'h4000, 16'd0);
      cmd(8'h08);
      chk("R6 zero read command", 32'(done_q), 32'd1);
      ack();
      cmd(8'h09);
      chk("R6 stop bit blocks", 32'(done_q), 32'd0);
      cmd(8'h10);
      chk("R6 zero write command", 32'(done_q), 32'd1);
      ack();
      cmd(8'h22);
      chk("R6 no dma bits", 32'(done_q), 32'd0);
      load(16'h4000, 16'd5);
      cmd(8'h10);
      chk("R6 nonzero count", 32'(done_q), 32'd0);
      load(16'h4000, 16'd0);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = 8'h08; done_ack = 1'b1;
      @(negedge clk); cmd_we = 1'b0; done_ack = 1'b0;
      chk("R9 set beats ack", 32'(done_q), 32'd1);

      // R7 range
      load(16'h0100, 16'd4);
      access(1'b0, 1'b0, 32'h0);
      chk("R7 byte out of range", dp_rdata, 32'h000000FF);
      wide_mode = 1'b1;
      access(1'b0, 1'b0, 32'h0);
      chk("R7 word out of range", dp_rdata, 32'h0000FFFF);
      access(1'b0, 1'b1, 32'h0);
      chk("R7 long out of range", dp_rdata, 32'hFFFFFFFF);
      chk("R7 pointer still moves", 32'(addr_q), 32'h0107);
      wide_mode = 1'b0;
      load(16'h4400, 16'd1);
      access(1'b1, 1'b0, 32'h77);
      load(16'h4000, 16'd1);
      access(1'b0, 1'b0, 32'h0);
      chk("R7 write past window dropped", dp_rdata, {24'h0, pat(16'h4000)});
      load(16'h0005, 16'd1);
      access(1'b1, 1'b0, 32'hA5);
      load(16'h0005, 16'd1);
      access(1'b0, 1'b0, 32'h0);
      chk("R7 prom byte", dp_rdata, 32'h000000A5);
      load(16'd28, 16'd4);
      access(1'b1, 1'b1, 32'h11223344);
      load(16'd28, 16'd4);
      access(1'b0, 1'b1, 32'h0);
      chk("R7 prom top long", dp_rdata, 32'h11223344);
      load(16'd30, 16'd4);
      access(1'b0, 1'b1, 32'h0);
      chk("R7 long straddling prom end", dp_rdata, 32'hFFFFFFFF);
      chk("R10 hold after idle", dp_rdata, 32'hFFFFFFFF);

      finish_run();
   end

endmodule